// File: doc/BRIEF.md
# Comparator Timer with 64-bit Free-Running Count

This peripheral keeps a 64-bit up-counter that advances by one on every cycle where the timer is switched on and the tick input is high. Software reaches it through a 32-bit register port addressed by byte offset. Each 64-bit quantity appears there as a low word and a high word. A single compare channel watches the count. Once the count has reached or passed the comparator, a sticky event flag is latched. The interrupt line follows that flag, gated by an enable bit.

An optional auto-increment mode gives periodic interrupts with no software reload. On every compare hit, the comparator moves forward by a programmable 32-bit step. The counter never stops or wraps because of an event. Software can read a coherent 64-bit value by reading the high word, then the low word, then the high word again. This works because a carry out of the low word reaches the high word on the same clock edge.

Top module: `t64_timer`

## Requirements
- R1: The count rises by exactly one on a clock edge where the control run bit (bit 0) is 1, `tick_en` is 1 and no counter word is written. In every other case it holds. It keeps counting after the event flag is set.
- R2: The count is one 64-bit value. Offset 0x00 reads bits 31:0 and offset 0x04 reads bits 63:32. A carry out of the low word appears in the high word on the same edge.
- R3: Writing offset 0x00 or 0x04 loads that counter word. The write takes priority over the increment. The other word holds its value in that cycle.
- R4: The event flag is status bit 0, at offset 0x0C. It is set on the edge after a cycle in which compare-enable (control bit 1) is 1 and the count is greater than or equal to the 64-bit comparator (low word at 0x10, high word at 0x14). While compare-enable is 0, the flag is never set, even when the comparator is written.
- R5: Writing 1 to status bit 0 clears the flag. Writing 0 has no effect. A hit in the same cycle wins over the clear, so the flag stays set.
- R6: `irq` is high exactly when the event flag is 1 and interrupt-enable (control bit 2) is 1.
- R7: The increment register is at 0x18. When auto-increment (control bit 3) is 1 and a hit occurs, the comparator becomes the comparator plus the zero-extended 32-bit increment on that same edge.
- R8: Reset clears every register and drives `irq` low. Control reads back only bits 3:0, with upper bits 0. Reads of unmapped offsets (for example 0x1C) return 0.
- R9: A write to either comparator word in a hit cycle takes priority over the auto-increment. The written word is loaded and the other word keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable tick (divide-by-one) |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
The bench drives the low word to all ones and applies a single tick. A design without a full 64-bit carry would leave the high word at zero, and a torn read would then go undetected.

It loads a comparator at or below the count while compare-enable is off. A design that compared without the enable would raise the flag. It clears the flag during a live hit. A design that gave the clear priority would drop the flag while the condition still holds.

Auto-increment is checked with an all-ones step, which catches a sign-extended or truncated add. It is also checked with a comparator write in the hit cycle, which catches a design that lets the increment override the write. A seeded random mix of writes and ticks then compares every register and `irq` against a bench model after every cycle.

// File: rtl/t64_pkg.sv
`timescale 1ns/1ps
package t64_pkg;
   // Byte offsets; software depends on these positions.
   localparam int OFS_CNT  = 'h00;
   localparam int OFS_CTRL = 'h08;
   localparam int OFS_STAT = 'h0C;
   localparam int OFS_CMP  = 'h10;
   localparam int OFS_INC  = 'h18;

   // Control bits 3..0, MSB first.
   typedef struct packed {
      logic auto_en;
      logic irq_en;
      logic cmp_en;
      logic run;
   } ctrl_t;
endpackage

// File: rtl/t64_counter.sv
`timescale 1ns/1ps
module t64_counter #(
   parameter int BUS_W  = 32,
   parameter int NWORDS = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      run,
   input  logic                      tick_en,
   input  logic [NWORDS-1:0]         wr_word,
   input  logic [BUS_W-1:0]          wdata,
   output logic [BUS_W*NWORDS-1:0]   count
);
   localparam int CNT_W = BUS_W * NWORDS;

   logic [CNT_W-1:0] base, nxt;

   // Full-width add: a carry reaches the upper words on the same edge.
   assign base = (run && tick_en && !(|wr_word)) ? count + CNT_W'(1) : count;

   for (genvar w = 0; w < NWORDS; w++) begin : g_word
      assign nxt[w*BUS_W +: BUS_W] = wr_word[w] ? wdata : base[w*BUS_W +: BUS_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) count <= '0;
      else        count <= nxt;
   end
endmodule

// File: rtl/t64_compare.sv
`timescale 1ns/1ps
module t64_compare #(
   parameter int BUS_W  = 32,
   parameter int NWORDS = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [BUS_W*NWORDS-1:0]   count,
   input  logic                      cmp_en,
   input  logic                      auto_en,
   input  logic [NWORDS-1:0]         wr_cmp,
   input  logic                      wr_inc,
   input  logic [BUS_W-1:0]          wdata,
   output logic                      hit,
   output logic [BUS_W*NWORDS-1:0]   cmp_q,
   output logic [BUS_W-1:0]          inc_q
);
   localparam int CNT_W = BUS_W * NWORDS;

   logic [CNT_W-1:0] base, nxt;

   assign hit  = cmp_en && (count >= cmp_q);
   // A software write to any comparator word blocks the step.
   assign base = (hit && auto_en && !(|wr_cmp)) ? cmp_q + CNT_W'(inc_q) : cmp_q;

   for (genvar w = 0; w < NWORDS; w++) begin : g_word
      assign nxt[w*BUS_W +: BUS_W] = wr_cmp[w] ? wdata : base[w*BUS_W +: BUS_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_q <= '0;
         inc_q <= '0;
      end else begin
         cmp_q <= nxt;
         if (wr_inc) inc_q <= wdata;
      end
   end
endmodule

// File: rtl/t64_regs.sv
`timescale 1ns/1ps
module t64_regs
   import t64_pkg::*;
#(
   parameter int BUS_W  = 32,
   parameter int NWORDS = 2,
   parameter int ADDR_W = 5
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_wr,
   input  logic [ADDR_W-1:0]         bus_addr,
   input  logic [BUS_W-1:0]          bus_wdata,
   input  logic                      hit,
   input  logic [BUS_W*NWORDS-1:0]   count,
   input  logic [BUS_W*NWORDS-1:0]   cmp_q,
   input  logic [BUS_W-1:0]          inc_q,
   output logic [NWORDS-1:0]         wr_cnt,
   output logic [NWORDS-1:0]         wr_cmp,
   output logic                      wr_inc,
   output ctrl_t                     ctrl_q,
   output logic                      flag_q,
   output logic [BUS_W-1:0]          bus_rdata
);
   localparam int WB = BUS_W / 8;

   logic wr_ctrl, wr_stat;

   for (genvar w = 0; w < NWORDS; w++) begin : g_dec
      assign wr_cnt[w] = bus_wr && (bus_addr == ADDR_W'(OFS_CNT + w*WB));
      assign wr_cmp[w] = bus_wr && (bus_addr == ADDR_W'(OFS_CMP + w*WB));
   end
   assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
   assign wr_stat = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
   assign wr_inc  = bus_wr && (bus_addr == ADDR_W'(OFS_INC));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         flag_q <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[$bits(ctrl_t)-1:0]);
         if (hit)                          flag_q <= 1'b1;
         else if (wr_stat && bus_wdata[0]) flag_q <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      for (int w = 0; w < NWORDS; w++) begin
         if (bus_addr == ADDR_W'(OFS_CNT + w*WB)) bus_rdata = count[w*BUS_W +: BUS_W];
         if (bus_addr == ADDR_W'(OFS_CMP + w*WB)) bus_rdata = cmp_q[w*BUS_W +: BUS_W];
      end
      if (bus_addr == ADDR_W'(OFS_CTRL)) bus_rdata = BUS_W'(ctrl_q);
      if (bus_addr == ADDR_W'(OFS_STAT)) bus_rdata = BUS_W'(flag_q);
      if (bus_addr == ADDR_W'(OFS_INC))  bus_rdata = inc_q;
   end
endmodule

// File: rtl/t64_timer.sv
`timescale 1ns/1ps
module t64_timer
   import t64_pkg::*;
#(
   parameter int CNT_W  = 64,
   parameter int BUS_W  = 32,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              irq
);
   localparam int NWORDS = CNT_W / BUS_W;

   if (NWORDS != 2 || CNT_W % BUS_W != 0) begin : g_bad_width
      $error("t64_timer: CNT_W must be exactly two bus words");
   end
   if (BUS_W % 8 != 0 || (1 << ADDR_W) <= OFS_INC + BUS_W/8 - 1) begin : g_bad_addr
      $error("t64_timer: ADDR_W too small or BUS_W not byte sized");
   end

   logic [NWORDS-1:0] wr_cnt, wr_cmp;
   logic              wr_inc, hit, flag_q;
   logic [CNT_W-1:0]  count_q, cmp_q;
   logic [BUS_W-1:0]  inc_q;
   ctrl_t             ctrl_q;

   t64_regs #(.BUS_W(BUS_W), .NWORDS(NWORDS), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .hit(hit), .count(count_q), .cmp_q(cmp_q),
      .inc_q(inc_q), .wr_cnt(wr_cnt), .wr_cmp(wr_cmp), .wr_inc(wr_inc),
      .ctrl_q(ctrl_q), .flag_q(flag_q), .bus_rdata(bus_rdata)
   );

   t64_counter #(.BUS_W(BUS_W), .NWORDS(NWORDS)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .tick_en(tick_en),
      .wr_word(wr_cnt), .wdata(bus_wdata), .count(count_q)
   );

   t64_compare #(.BUS_W(BUS_W), .NWORDS(NWORDS)) u_cmp (
      .clk(clk), .rst_n(rst_n), .count(count_q), .cmp_en(ctrl_q.cmp_en),
      .auto_en(ctrl_q.auto_en), .wr_cmp(wr_cmp), .wr_inc(wr_inc),
      .wdata(bus_wdata), .hit(hit), .cmp_q(cmp_q), .inc_q(inc_q)
   );

   assign irq = flag_q && ctrl_q.irq_en;
endmodule

// File: rtl/t64_checker.sv
`timescale 1ns/1ps
module t64_checker
   import t64_pkg::*;
#(
   parameter int CNT_W  = 64,
   parameter int BUS_W  = 32,
   parameter int ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_en,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [BUS_W-1:0]  bus_wdata,
   input logic              irq,
   input logic              hit,
   input logic              flag_q,
   input ctrl_t             ctrl_q,
   input logic [CNT_W-1:0]  count_q,
   input logic [CNT_W-1:0]  cmp_q,
   input logic [BUS_W-1:0]  inc_q
);
   logic cnt_wr, cmp_wr, clr_wr;
   assign cnt_wr = bus_wr && (bus_addr == ADDR_W'(OFS_CNT) || bus_addr == ADDR_W'(OFS_CNT + BUS_W/8));
   assign cmp_wr = bus_wr && (bus_addr == ADDR_W'(OFS_CMP) || bus_addr == ADDR_W'(OFS_CMP + BUS_W/8));
   assign clr_wr = bus_wr && (bus_addr == ADDR_W'(OFS_STAT)) && bus_wdata[0];

   a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.run && tick_en && !cnt_wr) |=> (count_q == $past(count_q) + CNT_W'(1)));
   a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!(ctrl_q.run && tick_en) && !cnt_wr) |=> $stable(count_q));
   a_r4_set: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> flag_q);
   a_r4_no_set_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q.cmp_en && !flag_q) |=> !flag_q);
   a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && !hit) |=> !flag_q);
   a_r6_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> (flag_q && ctrl_q.irq_en));
   a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && ctrl_q.auto_en && !cmp_wr) |=> (cmp_q == $past(cmp_q) + CNT_W'($past(inc_q))));
endmodule

bind t64_timer t64_checker #(.CNT_W(CNT_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_t64_timer.sv
`timescale 1ns/1ps
module tb_t64_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;

   // Reference model state
   logic [63:0] m_cnt = '0, m_cmp = '0;
   logic [31:0] m_inc = '0;
   logic [3:0]  m_ctrl = '0;
   logic        m_flag = 1'b0;

   always #5 clk = ~clk;

   t64_timer dut (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd(string req, logic [4:0] a, logic [31:0] exp);
      bus_addr = a;
      #0.2;
      check(req, bus_rdata, exp);
   endtask

   // One clock: drive at negedge, advance model at posedge.
   task automatic cyc(bit wr, logic [4:0] a, logic [31:0] d, bit tk);
      logic        hit, nflag;
      logic [63:0] ncnt, ncmp;
      @(negedge clk);
      bus_wr = wr; bus_addr = a; bus_wdata = d; tick_en = tk;
      hit  = m_ctrl[1] && (m_cnt >= m_cmp);
      ncnt = m_cnt;
      if (wr && a == 5'h00)      ncnt[31:0]  = d;
      else if (wr && a == 5'h04) ncnt[63:32] = d;
      else if (m_ctrl[0] && tk)  ncnt = m_cnt + 64'd1;
      nflag = hit ? 1'b1 : ((wr && a == 5'h0C && d[0]) ? 1'b0 : m_flag);
      ncmp = m_cmp;
      if (wr && a == 5'h10)      ncmp[31:0]  = d;
      else if (wr && a == 5'h14) ncmp[63:32] = d;
      else if (hit && m_ctrl[3]) ncmp = m_cmp + {32'd0, m_inc};
      @(posedge clk);
      #1;
      bus_wr = 1'b0; tick_en = 1'b0;
      m_cnt = ncnt; m_cmp = ncmp; m_flag = nflag;
      if (wr && a == 5'h18) m_inc = d;
      if (wr && a == 5'h08) m_ctrl = d[3:0];
   endtask

   task automatic wr(logic [4:0] a, logic [31:0] d);
      cyc(1'b1, a, d, 1'b0);
   endtask

   task automatic verify_all(string req);
      rd(req, 5'h00, m_cnt[31:0]);
      rd(req, 5'h04, m_cnt[63:32]);
      rd(req, 5'h08, {28'd0, m_ctrl});
      rd(req, 5'h0C, {31'd0, m_flag});
      rd(req, 5'h10, m_cmp[31:0]);
      rd(req, 5'h14, m_cmp[63:32]);
      rd(req, 5'h18, m_inc);
      rd(req, 5'h1C, 32'd0);
      check(req, {31'd0, irq}, {31'd0, m_flag & m_ctrl[2]});
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R8 reset state
      verify_all("R8 reset");
      // R1 no tick means no count
      wr(5'h08, 32'h1);
      repeat (3) cyc(1'b0, 5'h00, 0, 1'b0);
      rd("R1 no tick", 5'h00, 32'd0);
      repeat (5) cyc(1'b0, 5'h00, 0, 1'b1);
      rd("R1 five ticks", 5'h00, 32'd5);
      wr(5'h08, 32'h0);
      repeat (3) cyc(1'b0, 5'h00, 0, 1'b1);
      rd("R1 disabled holds", 5'h00, 32'd5);
      // R2 carry into the high word
      wr(5'h00, 32'hFFFF_FFFF);
      wr(5'h04, 32'h0);
      wr(5'h08, 32'h1);
      cyc(1'b0, 5'h00, 0, 1'b1);
      rd("R2 low wrap", 5'h00, 32'd0);
      rd("R2 high carry", 5'h04, 32'd1);
      // R3 write beats increment
      cyc(1'b1, 5'h00, 32'h100, 1'b1);
      rd("R3 write wins", 5'h00, 32'h100);
      rd("R3 other word", 5'h04, 32'd1);
      // R4 no flag while compare disabled
      wr(5'h10, 32'h0);
      wr(5'h14, 32'h0);
      cyc(1'b0, 5'h00, 0, 1'b0);
      rd("R4 cmp off no flag", 5'h0C, 32'd0);
      wr(5'h08, 32'h3);
      cyc(1'b0, 5'h00, 0, 1'b0);
      rd("R4 ge sets flag", 5'h0C, 32'd1);
      check("R6 irq masked", {31'd0, irq}, 32'd0);
      // R5 clear loses to live hit; zero write ignored
      wr(5'h0C, 32'h1);
      rd("R5 hit beats clear", 5'h0C, 32'd1);
      wr(5'h08, 32'h1);
      wr(5'h0C, 32'h0);
      rd("R5 zero write ignored", 5'h0C, 32'd1);
      wr(5'h0C, 32'h1);
      rd("R5 clear", 5'h0C, 32'd0);
      // R6 irq gating
      wr(5'h08, 32'h3);
      cyc(1'b0, 5'h00, 0, 1'b0);
      check("R6 irq off", {31'd0, irq}, 32'd0);
      wr(5'h08, 32'h7);
      check("R6 irq on", {31'd0, irq}, 32'd1);
      // R7 periodic step
      wr(5'h08, 32'h0);
      wr(5'h00, 32'h0);
      wr(5'h04, 32'h0);
      wr(5'h10, 32'd10);
      wr(5'h18, 32'd5);
      wr(5'h0C, 32'h1);
      wr(5'h08, 32'hB);
      repeat (11) cyc(1'b0, 5'h00, 0, 1'b1);
      rd("R1 counts past event", 5'h00, 32'd11);
      rd("R7 step by five", 5'h10, 32'd15);
      rd("R7 flag", 5'h0C, 32'd1);
      // R7 zero extension of an all-ones step
      wr(5'h08, 32'h0);
      wr(5'h10, 32'd5);
      wr(5'h18, 32'hFFFF_FFFF);
      wr(5'h08, 32'hA);
      cyc(1'b0, 5'h00, 0, 1'b0);
      rd("R7 zext low", 5'h10, 32'd4);
      rd("R7 zext high", 5'h14, 32'd1);
      // R9 comparator write beats auto-increment
      wr(5'h08, 32'h0);
      wr(5'h14, 32'h0);
      wr(5'h10, 32'h0);
      wr(5'h08, 32'hA);
      wr(5'h10, 32'd3);
      rd("R9 write wins low", 5'h10, 32'd3);
      rd("R9 write wins high", 5'h14, 32'd0);
      // R8 control readback width, unmapped read
      wr(5'h08, 32'hFFFF_FFF5);
      rd("R8 ctrl bits", 5'h08, 32'h5);
      rd("R8 unmapped", 5'h1C, 32'd0);
      verify_all("R8 model sync");
      // Random mix against the model (R1-R7 behaviour)
      for (int i = 0; i < 4000; i++) begin
         bit          w  = ($urandom_range(0, 9) < 3);
         logic [4:0]  a  = 5'($urandom_range(0, 7) * 4);
         logic [31:0] d  = ($urandom_range(0, 7) == 0) ? $urandom() : 32'($urandom_range(0, 60));
         bit          tk = ($urandom_range(0, 3) != 0);
         if (a == 5'h04 || a == 5'h14) d = ($urandom_range(0, 15) == 0) ? 32'd1 : 32'd0;
         cyc(w, a, d, tk);
         verify_all("R1 R4 R5 R6 R7 random");
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule